// File: doc/BRIEF.md
# Shift and Rotate-Through-Carry Unit

This block is the shifting datapath used by integer micro-operations. In one combinational pass it can shift left, shift right with zero fill, shift right with sign fill, rotate left or right, or rotate left or right through the carry flag. The count comes either from a register operand or from a short immediate. The operand size may be 1, 2, 4 or 8 bytes. Only the active width of the old destination value is replaced. The bits above that width pass through from the old destination without change.

The unit also produces a carry-out: the last bit pushed out of the operand. Flag logic outside the block uses it. The block holds no state and has no reset. Each output depends only on the inputs present in the same cycle, so it fits between the register read stage and the write-back stage of an execution pipe.

Top module: `shift_rotate_unit`

## Requirements
- R1: The effective count n is taken from `cnt_imm` when `use_imm` is 1 and from `cnt_reg` when it is 0. n is the low 6 bits of that operand when `size` is 3, and the low 5 bits otherwise. All other count bits have no effect.
- R2: `size` codes 0, 1, 2 and 3 select an active width W of 8, 16, 32 or 64 bits. Bits of `dst_new` at or above W always equal the same bits of `dst_old`. The result bits are computed only from `src[W-1:0]`.
- R3: `op` = 0 shifts left with zero fill for n > 0. `cf_out` is source bit W-n, or 0 when n > W.
- R4: `op` = 1 shifts right with zero fill for n > 0. `cf_out` is source bit n-1, or 0 when n > W.
- R5: `op` = 2 shifts right and fills with source bit W-1 for n > 0. `cf_out` is source bit n-1, or that sign bit when n > W.
- R6: `op` = 3 rotates left and `op` = 4 rotates right by n mod W, for n > 0. `cf_out` is result bit 0 for a left rotate and result bit W-1 for a right rotate.
- R7: `op` = 5 rotates left through carry for n > 0. The W+1-bit ring formed by `cf_in` above the source is rotated by q = n mod (W+1). For q > 0, `cf_in` lands at result bit q-1, and `cf_out` is source bit W-q. For q = 0, the result is the source and `cf_out` = `cf_in`.
- R8: `op` = 6 rotates right through carry by q = n mod (W+1). For q > 0, `cf_in` lands at result bit W-q, and `cf_out` is source bit q-1. For q = 0, the result is the source and `cf_out` = `cf_in`.
- R9: For any rotate (`op` 3 to 6) with n = 0, `dst_new` equals `dst_old` and `cf_out` equals `cf_in`.
- R10: For any shift (`op` 0 to 2) with n = 0, the active width of `dst_new` is the source, and `cf_out` equals `cf_in`.
- R11: `op` = 7 is a no-op. `dst_new` equals `dst_old` and `cf_out` equals `cf_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 3 | Operation code (see R3 to R11) |
| size | input | 2 | Operand size code (see R2) |
| use_imm | input | 1 | Select the immediate count instead of the register count |
| cnt_reg | input | 64 | Register count operand |
| cnt_imm | input | 8 | Immediate count operand |
| src | input | 64 | Value to shift or rotate |
| dst_old | input | 64 | Previous destination value, merged into the result |
| cf_in | input | 1 | Incoming carry flag |
| dst_new | output | 64 | Merged destination value |
| cf_out | output | 1 | Last bit shifted out |

## Verification
Immediate assertions run on every input change. They check four things: that the bits above the active width are preserved, that the fill bit at the top of a right shift and the bottom of a left shift is correct, that a zero-count rotate holds the destination, and that an 8-byte rotate through carry places the carry at the right bit. The exact value of every result bit, the carry-out in every mode, and the modulo behaviour of counts longer than a narrow width can only be shown by the bench sweep. That sweep covers every operation, size and 6-bit count against a bit-serial model.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shf_op_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } shf_size_e;

    function automatic logic is_rotate(shf_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    endfunction

endpackage

// File: rtl/shf_count.sv
`timescale 1ns/1ps
module shf_count #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic              use_imm,
    input  logic [1:0]        size,
    output logic [CNT_W-1:0]  n,
    output logic [CNT_W-1:0]  rot_amt,
    output logic [CNT_W-1:0]  rc_amt
);
    localparam int NSZ = 4;

    logic [CNT_W-1:0] sel;
    logic [CNT_W-1:0] rot_tab [NSZ];
    logic [CNT_W-1:0] rc_tab  [NSZ];
    logic             unused_hi;

    assign unused_hi = ^{cnt_reg[DATA_W-1:CNT_W], cnt_imm[IMM_W-1:CNT_W]};

    // Count source select and size-dependent masking
    assign sel = use_imm ? cnt_imm[CNT_W-1:0] : cnt_reg[CNT_W-1:0];
    assign n   = (size == 2'd3) ? sel : {1'b0, sel[CNT_W-2:0]};

    // Per-size rotate amounts: modulo W for plain rotates, modulo W+1 through carry
    for (genvar g = 0; g < NSZ; g++) begin : g_size
        localparam int WB = DATA_W >> (NSZ - 1 - g);
        assign rot_tab[g] = n & CNT_W'(WB - 1);
        assign rc_tab[g]  = CNT_W'({1'b0, n} % (CNT_W + 1)'(WB + 1));
    end

    assign rot_amt = rot_tab[size];
    assign rc_amt  = rc_tab[size];

endmodule

// File: rtl/shf_core.sv
`timescale 1ns/1ps
module shf_core
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic              cf_in,
    input  logic [CNT_W-1:0]  n,
    input  logic [CNT_W-1:0]  rot_amt,
    input  logic [CNT_W-1:0]  rc_amt,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              keep
);
    localparam int EW = 2 * DATA_W;
    localparam int AW = $clog2(EW);

    shf_op_e          op_e;
    logic [AW-1:0]    w, na, n1, r, q, q1;
    logic [EW-1:0]    wm, s, sx, cw, t_main, t_aux;
    logic             sign;

    assign op_e = shf_op_e'(op);

    always_comb begin
        w    = AW'(DATA_W) >> (2'd3 - size);
        wm   = (EW'(1) << w) - EW'(1);
        s    = {{DATA_W{1'b0}}, src} & wm;
        sign = s[w - AW'(1)];
        sx   = sign ? (s | ~wm) : s;
        cw   = EW'(cf_in);
        na   = AW'(n);
        n1   = na - AW'(1);
        r    = AW'(rot_amt);
        q    = AW'(rc_amt);
        q1   = q - AW'(1);

        t_main = s;
        t_aux  = '0;
        cout   = cf_in;
        keep   = 1'b0;

        unique case (op_e)
            OP_SHL: begin
                t_main = s << na;
                t_aux  = s << na;
                cout   = t_aux[w];
            end
            OP_SHR: begin
                t_main = s >> na;
                t_aux  = s >> n1;
                cout   = t_aux[0];
            end
            OP_SAR: begin
                t_main = sx >> na;
                t_aux  = sx >> n1;
                cout   = t_aux[0];
            end
            OP_ROL: begin
                t_main = (s << r) | (s >> (w - r));
                t_aux  = t_main;
                cout   = t_aux[0];
            end
            OP_ROR: begin
                t_main = (s >> r) | (s << (w - r));
                t_aux  = t_main;
                cout   = t_aux[w - AW'(1)];
            end
            OP_RCL: begin
                if (q != '0) begin
                    t_main = (s << q) | (cw << q1) | (s >> (w + AW'(1) - q));
                    t_aux  = s >> (w - q);
                    cout   = t_aux[0];
                end
            end
            OP_RCR: begin
                if (q != '0) begin
                    t_main = (s >> q) | (cw << (w - q)) | (s << (w + AW'(1) - q));
                    t_aux  = s >> q1;
                    cout   = t_aux[0];
                end
            end
            OP_NOP: begin
                keep = 1'b1;
            end
        endcase

        // Zero masked count: shifts pass the source, rotates hold the destination
        if (na == '0 && op_e != OP_NOP) begin
            t_main = s;
            cout   = cf_in;
            keep   = is_rotate(op_e);
        end

        res = t_main[DATA_W-1:0] & wm[DATA_W-1:0];
    end

endmodule

// File: rtl/shf_merge.sv
`timescale 1ns/1ps
module shf_merge #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        size,
    input  logic              keep,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] dst_old,
    output logic [DATA_W-1:0] dst_new
);
    localparam int WW = $clog2(DATA_W) + 1;

    logic [WW-1:0]     w;
    logic [DATA_W-1:0] wmask;

    always_comb begin
        w     = WW'(DATA_W) >> (2'd3 - size);
        wmask = (size == 2'd3) ? '1 : ((DATA_W'(1) << w) - DATA_W'(1));
        if (keep) dst_new = dst_old;
        else      dst_new = (dst_old & ~wmask) | (res & wmask);
    end

endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst_old,
    input  logic              cf_in,
    output logic [DATA_W-1:0] dst_new,
    output logic              cf_out
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]  n, rot_amt, rc_amt;
    logic [DATA_W-1:0] res;
    logic              keep;

    shf_count #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_count (
        .cnt_reg (cnt_reg),
        .cnt_imm (cnt_imm),
        .use_imm (use_imm),
        .size    (size),
        .n       (n),
        .rot_amt (rot_amt),
        .rc_amt  (rc_amt)
    );

    shf_core #(.DATA_W(DATA_W)) u_core (
        .op      (op),
        .size    (size),
        .src     (src),
        .cf_in   (cf_in),
        .n       (n),
        .rot_amt (rot_amt),
        .rc_amt  (rc_amt),
        .res     (res),
        .cout    (cf_out),
        .keep    (keep)
    );

    shf_merge #(.DATA_W(DATA_W)) u_merge (
        .size    (size),
        .keep    (keep),
        .res     (res),
        .dst_old (dst_old),
        .dst_new (dst_new)
    );

endmodule

// File: rtl/shift_rotate_unit_chk.sv
`timescale 1ns/1ps
module shift_rotate_unit_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic              use_imm,
    input logic [DATA_W-1:0] cnt_reg,
    input logic [IMM_W-1:0]  cnt_imm,
    input logic [DATA_W-1:0] src,
    input logic [DATA_W-1:0] dst_old,
    input logic              cf_in,
    input logic [DATA_W-1:0] dst_new,
    input logic              cf_out
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int WW    = CNT_W + 1;

    logic [CNT_W-1:0]  sel, n, top, rcl_pos, rcr_pos;
    logic [WW-1:0]     w;
    logic [DATA_W-1:0] wm;
    logic              unused_chk;

    assign unused_chk = ^{cnt_reg[DATA_W-1:CNT_W], cnt_imm[IMM_W-1:CNT_W]};

    always_comb begin
        sel     = use_imm ? cnt_imm[CNT_W-1:0] : cnt_reg[CNT_W-1:0];
        n       = (size == 2'd3) ? sel : {1'b0, sel[CNT_W-2:0]};
        w       = WW'(DATA_W) >> (2'd3 - size);
        wm      = (size == 2'd3) ? '1 : ((DATA_W'(1) << w) - DATA_W'(1));
        top     = CNT_W'(w - WW'(1));
        rcl_pos = n - CNT_W'(1);
        rcr_pos = CNT_W'(WW'(DATA_W) - WW'(n));

        // R2: upper bits of the destination are always preserved
        p_merge_upper_r2: assert ((dst_new & ~wm) == (dst_old & ~wm))
            else $error("p_merge_upper_r2");

        // R3: left shift brings a zero into bit 0
        if (op == 3'd0 && n != '0)
            p_shl_low_zero_r3: assert (dst_new[0] == 1'b0)
                else $error("p_shl_low_zero_r3");

        // R4: logical right shift clears the top active bit
        if (op == 3'd1 && n != '0)
            p_shr_top_zero_r4: assert (dst_new[top] == 1'b0)
                else $error("p_shr_top_zero_r4");

        // R5: arithmetic right shift keeps the sign bit
        if (op == 3'd2)
            p_sar_sign_r5: assert (dst_new[top] == src[top])
                else $error("p_sar_sign_r5");

        // R7: full-width rotate left through carry places carry at n-1
        if (op == 3'd5 && size == 2'd3 && n != '0)
            p_rcl_carry_pos_r7: assert (dst_new[rcl_pos] == cf_in)
                else $error("p_rcl_carry_pos_r7");

        // R8: full-width rotate right through carry places carry at W-n
        if (op == 3'd6 && size == 2'd3 && n != '0)
            p_rcr_carry_pos_r8: assert (dst_new[rcr_pos] == cf_in)
                else $error("p_rcr_carry_pos_r8");

        // R9: zero-count rotate leaves destination and carry alone
        if (op >= 3'd3 && op <= 3'd6 && n == '0)
            p_rot_zero_keep_r9: assert (dst_new == dst_old && cf_out == cf_in)
                else $error("p_rot_zero_keep_r9");

        // R10: zero-count shift passes the source through
        if (op <= 3'd2 && n == '0)
            p_shift_zero_pass_r10: assert ((dst_new & wm) == (src & wm) && cf_out == cf_in)
                else $error("p_shift_zero_pass_r10");

        // R11: reserved code is a no-op
        if (op == 3'd7)
            p_nop_hold_r11: assert (dst_new == dst_old && cf_out == cf_in)
                else $error("p_nop_hold_r11");
    end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .op      (op),
    .size    (size),
    .use_imm (use_imm),
    .cnt_reg (cnt_reg),
    .cnt_imm (cnt_imm),
    .src     (src),
    .dst_old (dst_old),
    .cf_in   (cf_in),
    .dst_new (dst_new),
    .cf_out  (cf_out)
);

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic        use_imm = 1'b0;
    logic [63:0] cnt_reg = '0;
    logic [7:0]  cnt_imm = '0;
    logic [63:0] src = '0;
    logic [63:0] dst_old = '0;
    logic        cf_in = 1'b0;
    logic [63:0] dst_new;
    logic        cf_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shift_rotate_unit uut (
        .op      (op),
        .size    (size),
        .use_imm (use_imm),
        .cnt_reg (cnt_reg),
        .cnt_imm (cnt_imm),
        .src     (src),
        .dst_old (dst_old),
        .cf_in   (cf_in),
        .dst_new (dst_new),
        .cf_out  (cf_out)
    );

    // Bit-serial reference: one single-bit step per count
    function automatic void model(input logic [2:0] mop, input logic [1:0] msz,
                                  input logic [63:0] msrc, input logic [63:0] mold,
                                  input int n, input logic mcf,
                                  output logic [63:0] mnew, output logic mc);
        int w = 8 << msz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] v = msrc & mask;
        logic sgn = v[w-1];
        logic c = mcf;
        logic nc;
        if (mop == 3'd7 || (mop >= 3'd3 && n == 0)) begin
            mnew = mold;
            mc   = mcf;
            return;
        end
        for (int i = 0; i < n; i++) begin
            case (mop)
                3'd0: begin c = v[w-1]; v = (v << 1) & mask; end
                3'd1: begin c = v[0]; v = v >> 1; end
                3'd2: begin c = v[0]; v = (v >> 1) | (64'(sgn) << (w-1)); end
                3'd3: begin c = v[w-1]; v = ((v << 1) | 64'(c)) & mask; end
                3'd4: begin c = v[0]; v = (v >> 1) | (64'(c) << (w-1)); end
                3'd5: begin nc = v[w-1]; v = ((v << 1) | 64'(c)) & mask; c = nc; end
                default: begin nc = v[0]; v = (v >> 1) | (64'(c) << (w-1)); c = nc; end
            endcase
        end
        mnew = (mold & ~mask) | (v & mask);
        mc   = c;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp,
                         input logic gc, input logic ec);
        checks++;
        if (got !== exp || gc !== ec) begin
            fails++;
            $display("FAIL %s op=%0d size=%0d: dst_new=%h cf_out=%b expected dst_new=%h cf_out=%b",
                     tag, op, size, got, gc, exp, ec);
        end
    endtask

    initial begin
        logic [63:0] pats [3];
        logic [63:0] exp_d;
        logic        exp_c;
        string       tag;
        int          n;
        pats[0] = 64'h8123_4567_89AB_CDEF;
        pats[1] = 64'h7F5A_3C96_0F1E_2D4B;
        pats[2] = 64'hC3A5_0000_FFFF_8001;

        repeat (2) @(negedge clk);
        #1;
        // Idle inputs: zero-count left shift of zero (R10)
        check("R10", dst_new, 64'd0, cf_out, 1'b0);
        rst = 1'b0;

        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 8; o++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int k = 0; k < 64; k++) begin
                        @(negedge clk);
                        op      = 3'(o);
                        size    = 2'(s);
                        src     = pats[p];
                        dst_old = ~pats[p] ^ 64'h5A5A_F00F_3CC3_9669;
                        cf_in   = 1'(p) ^ 1'(k >> 1);
                        use_imm = 1'(k) ^ 1'(p);
                        cnt_imm = {2'b10, 6'(k)} ^ (use_imm ? 8'h00 : 8'h15);
                        cnt_reg = use_imm ? {58'h2AB_CDEF_0123_4567, 6'(~k)}
                                          : {58'h155_1234_5678_9ABC, 6'(k)};
                        n = (s == 3) ? k : (k & 31);
                        #2;
                        model(op, size, src, dst_old, n, cf_in, exp_d, exp_c);
                        if (o == 7)                   tag = "R11";
                        else if (n == 0 && o >= 3)    tag = "R9";
                        else if (n == 0)              tag = "R10";
                        else if (s != 3 && k >= 32)   tag = "R1";
                        else if (o == 0)              tag = "R3";
                        else if (o == 1)              tag = "R4";
                        else if (o == 2)              tag = "R5";
                        else if (o <= 4)              tag = "R6";
                        else if (o == 5)              tag = "R7";
                        else                          tag = "R8";
                        check(tag, dst_new, exp_d, cf_out, exp_c);
                        // R2: bits above the active width come from dst_old
                        if (s != 3)
                            check("R2", dst_new >> (8 << s), dst_old >> (8 << s), 1'b0, 1'b0);
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule